// File: doc/BRIEF.md
# Iterative Multi-Mode Shifter

This block carries out shift-class instructions on a 16-bit accumulator A, a 16-bit partner register B and a one-bit carry C. A one-cycle start pulse loads the instruction word and the three operands. The unit then moves the data one bit position on each clock, for as many clocks as the six-bit count in the instruction asks. When the last step is done it raises a single-cycle done pulse, and the results are on the A, B and C outputs from that cycle on.

The type field chooses between eight behaviours, each either leftward or rightward. Four of them act on A alone and four on a 31-bit long word. The long word is A followed by the low fifteen bits of B, so the top bit of B never moves. Besides the plain logical, arithmetic and rotate kinds there is a hybrid kind. Shifted left, it rotates and records sign overflow in C. Shifted right, it ORs each bit that falls off the bottom into the top position while still keeping the sign. A start that arrives while a shift is still running is ignored.

Top module: `iter_shifter`

## Requirements
- R1: The instruction carries the type in bits [9:6] and the count (0 to 63) in bits [5:0]. Type bit 9 set means left and clear means right. Type bit 8 clear selects the 31-bit long word and set selects A alone. Bits [7:6] pick the kind: 0 logical, 1 arithmetic, 2 rotate, 3 hybrid.
- R2: Logical shifts fill the vacated position with 0, and C ends equal to the last bit shifted out.
- R3: An arithmetic right shift copies the sign into the top position, and C ends equal to the last bit shifted out.
- R4: An arithmetic left shift fills with 0. C ends at 1 when the sign bit changed on any step and at 0 otherwise, whatever C was before.
- R5: A rotate feeds the bit leaving one end back in at the other end, and C ends equal to the last bit that moved across.
- R6: Long shifts act on {A, B[14:0]} as a 31-bit word, and B[15] keeps its value. Shifts on A alone leave all of B unchanged.
- R7: A hybrid left shift rotates the data, and C follows the overflow rule of R4.
- R8: In a hybrid right shift the new top bit is the old sign ORed with the bit leaving the bottom, and C ends equal to the last bit shifted out.
- R9: A count of 0 raises done on the cycle right after the start edge, with A, B and C equal to the loaded values.
- R10: For a count N of 1 or more, done is high on the clock cycle N edges after the start edge and lasts one cycle. A start that arrives while a shift is running has no effect.
- R11: After reset, done is low and A, B and C are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load instruction and operands, accepted when idle |
| instr | input | 16 | Shift instruction word |
| a_in | input | 16 | A operand |
| b_in | input | 16 | B operand |
| c_in | input | 1 | Carry operand |
| a_out | output | 16 | A result |
| b_out | output | 16 | B result |
| c_out | output | 1 | Carry result |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can fall on the same clock edge. The first is the last step of a shift together with a new start. The second is the shifting of data together with the updating of C, which is either the last bit out or the overflow bit that was clearing at load and sticks once set. The bench raises start in the middle of a ten-step shift and checks that the final A and C, and the done cycle, belong to the first instruction only. Overflow cases are chosen so that C arrives at 1 set and must end at 0, and so that the sign changes only on the last step. This shows that C is cleared at load and that it sticks once set.

// File: rtl/iter_shifter.sv
module iter_shifter #(
  parameter int W  = 16,
  parameter int CW = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [15:0]  instr,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         c_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         c_out,
  output logic         done
);
  localparam int LW = 2*W - 1;

  logic [W-1:0]  a_q, b_q;
  logic          c_q, busy_q, done_q;
  logic [3:0]    t_q;
  logic [CW-1:0] cnt_q;

  wire       left    = t_q[3];
  wire       long_m  = ~t_q[2];
  wire [1:0] kind    = t_q[1:0];
  wire       ovf_m   = left & kind[0];

  logic [LW-1:0] lx, ly;
  logic [W-1:0]  sy;
  logic          l_out, l_ovf, s_out, s_ovf;

  always_comb begin
    lx = {a_q, b_q[W-2:0]};
    if (left) begin
      ly    = {lx[LW-2:0], kind[1] & lx[LW-1]};
      l_out = lx[LW-1];
      l_ovf = lx[LW-1] ^ lx[LW-2];
    end else begin
      ly    = {(kind[0] & lx[LW-1]) | (kind[1] & lx[0]), lx[LW-1:1]};
      l_out = lx[0];
      l_ovf = 1'b0;
    end
  end

  always_comb begin
    if (left) begin
      sy    = {a_q[W-2:0], kind[1] & a_q[W-1]};
      s_out = a_q[W-1];
      s_ovf = a_q[W-1] ^ a_q[W-2];
    end else begin
      sy    = {(kind[0] & a_q[W-1]) | (kind[1] & a_q[0]), a_q[W-1:1]};
      s_out = a_q[0];
      s_ovf = 1'b0;
    end
  end

  wire [W-1:0] na   = long_m ? ly[LW-1:W-1] : sy;
  wire [W-1:0] nb   = long_m ? {b_q[W-1], ly[W-2:0]} : b_q;
  wire         sout = long_m ? l_out : s_out;
  wire         sovf = long_m ? l_ovf : s_ovf;
  wire         nc   = ovf_m ? (c_q | sovf) : sout;

  wire [CW-1:0] new_cnt = instr[CW-1:0];
  wire          accept  = start & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; c_q <= 1'b0;
      t_q <= '0; cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        a_q   <= a_in;
        b_q   <= b_in;
        t_q   <= instr[CW+3:CW];
        cnt_q <= new_cnt;
        if (new_cnt == '0) begin
          c_q    <= c_in;
          done_q <= 1'b1;
        end else begin
          c_q    <= (instr[CW+3] & instr[CW]) ? 1'b0 : c_in;
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        a_q   <= na;
        b_q   <= nb;
        c_q   <= nc;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign a_out = a_q;
  assign b_out = b_q;
  assign c_out = c_q;
  assign done  = done_q;

  // R6
  b_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(b_q[W-1]));
  // R6
  b_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && t_q[2] |=> $stable(b_q));
  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && ovf_m && c_q |=> c_q);
  // R9
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && new_cnt == '0 |=> done && a_out == $past(a_in) && b_out == $past(b_in) && c_out == $past(c_in));
  // R10
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);
  // R10
  count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> cnt_q == $past(cnt_q) - 1'b1);
  // R10
  busy_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q != '0);
endmodule

// File: tb/tb_iter_shifter.sv
module tb_iter_shifter;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, c_in = 1'b0;
  logic [15:0] instr = '0, a_in = '0, b_in = '0;
  logic [15:0] a_out, b_out;
  logic        c_out, done;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  iter_shifter dut (.clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .a_in(a_in), .b_in(b_in), .c_in(c_in), .a_out(a_out), .b_out(b_out),
    .c_out(c_out), .done(done));

  function automatic logic [15:0] op(input logic [3:0] t, input logic [5:0] n);
    return {6'b010000, t, n};
  endfunction

  // instr, a, b, c, expected a, expected b, expected c
  localparam int NV = 19;
  localparam logic [81:0] VEC [NV] = '{
    {6'b010000, 4'd4,  6'd4,  16'h8F31, 16'h1234, 1'b0, 16'h08F3, 16'h1234, 1'b0}, // R2
    {6'b010000, 4'd12, 6'd3,  16'hA001, 16'h1234, 1'b0, 16'h0008, 16'h1234, 1'b1}, // R2
    {6'b010000, 4'd5,  6'd2,  16'h8004, 16'h0000, 1'b1, 16'hE001, 16'h0000, 1'b0}, // R3
    {6'b010000, 4'd13, 6'd1,  16'h4000, 16'h0000, 1'b0, 16'h8000, 16'h0000, 1'b1}, // R4
    {6'b010000, 4'd13, 6'd2,  16'h0011, 16'h0000, 1'b1, 16'h0044, 16'h0000, 1'b0}, // R4
    {6'b010000, 4'd6,  6'd4,  16'h123C, 16'h0000, 1'b0, 16'hC123, 16'h0000, 1'b1}, // R5
    {6'b010000, 4'd14, 6'd8,  16'h12F4, 16'h0000, 1'b1, 16'hF412, 16'h0000, 1'b0}, // R5
    {6'b010000, 4'd0,  6'd4,  16'h0003, 16'h8005, 1'b0, 16'h0000, 16'h9800, 1'b0}, // R6
    {6'b010000, 4'd8,  6'd1,  16'h8000, 16'h4001, 1'b0, 16'h0001, 16'h0002, 1'b1}, // R6
    {6'b010000, 4'd1,  6'd1,  16'h8001, 16'h8000, 1'b1, 16'hC000, 16'hC000, 1'b0}, // R6 R3
    {6'b010000, 4'd10, 6'd1,  16'h8000, 16'h0000, 1'b0, 16'h0000, 16'h0001, 1'b1}, // R5 R6
    {6'b010000, 4'd15, 6'd1,  16'hC000, 16'h0000, 1'b1, 16'h8001, 16'h0000, 1'b0}, // R7
    {6'b010000, 4'd7,  6'd2,  16'h0001, 16'h0000, 1'b0, 16'hC000, 16'h0000, 1'b0}, // R8
    {6'b010000, 4'd3,  6'd1,  16'h0000, 16'h8001, 1'b0, 16'h8000, 16'h8000, 1'b1}, // R8
    {6'b010000, 4'd11, 6'd1,  16'h4000, 16'h0000, 1'b0, 16'h8000, 16'h0000, 1'b1}, // R7
    {6'b010000, 4'd9,  6'd1,  16'h0000, 16'h4000, 1'b1, 16'h0001, 16'h0000, 1'b0}, // R4 R6
    {6'b010000, 4'd2,  6'd1,  16'h0000, 16'h8001, 1'b0, 16'h8000, 16'h8000, 1'b1}, // R6 R1
    {6'b010000, 4'd14, 6'd63, 16'h8001, 16'h0000, 1'b1, 16'hC000, 16'h0000, 1'b0}, // R10
    {6'b010000, 4'd4,  6'd0,  16'h1234, 16'h5678, 1'b1, 16'h1234, 16'h5678, 1'b1}  // R9
  };

  task automatic check(input string req, input logic [48:0] act, input logic [48:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] i, input logic [15:0] a, input logic [15:0] b,
                     input logic c, output int lat);
    @(negedge clk);
    instr = i; a_in = a; b_in = b; c_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    if (lat >= 300) begin
      fails++;
      $display("FAIL watchdog: done never rose");
    end
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R11
    check("R11 reset", {a_out, b_out, c_out, done, 15'd0}, 49'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [81:0] v;
      v = VEC[k];
      run(v[81:66], v[65:50], v[49:34], v[33], lat);
      check($sformatf("R1 vector %0d data", k), {a_out, b_out, c_out, 16'd0},
            {v[32:17], v[16:1], v[0], 16'd0});
      check($sformatf("R10 vector %0d latency", k), 49'(lat), 49'(v[71:66]));
    end

    // R10: done lasts one cycle
    run(op(4'd6, 6'd3), 16'h0001, 16'h0000, 1'b0, lat);
    @(negedge clk);
    check("R10 done single pulse", 49'(done), 49'd0);

    // R10: start while running is ignored
    @(negedge clk);
    instr = op(4'd4, 6'd10); a_in = 16'hFFFF; b_in = 16'h0F0F; c_in = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    repeat (3) begin @(negedge clk); lat++; end
    instr = op(4'd12, 6'd1); a_in = 16'h0000; b_in = 16'h0000; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 300) begin @(negedge clk); lat++; end
    check("R10 start ignored while busy", {a_out, b_out, c_out, 16'd0},
          {16'h003F, 16'h0F0F, 1'b1, 16'd0});
    check("R10 busy latency", 49'(lat), 49'd10);

    // R9: zero count with clear carry, back to back
    run(op(4'd13, 6'd0), 16'h4000, 16'hFFFF, 1'b0, lat);
    check("R9 zero count unchanged", {a_out, b_out, c_out, 16'd0},
          {16'h4000, 16'hFFFF, 1'b0, 16'd0});
    check("R9 zero count latency", 49'(lat), 49'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule